// File: doc/BRIEF.md
# Gate-Driver Short-Circuit Fault Supervisor

This block is the digital supervisor inside a power-transistor gate driver. It watches the PWM turn-on command together with three comparator outputs that are already digital: integrated gate charge above its reference, gate voltage above its reference, and gate leakage current present. From these it decides whether a turn-on has run into a hard-switching short circuit.

The charge test has no fixed blanking window. The block reads the charge comparator at the moment the gate-voltage comparator rises. A turn-on that arrives at the voltage threshold with too little charge is a short circuit. A second, slower path treats gate leakage as a fault once a blanking window after the PWM rising edge has passed.

On a fault the block latches a flag and puts the driver output into high impedance. After a programmable delay it enables the soft-shutdown discharge path. The flag holds until the PWM command goes low. The block also drives the charge-integrator reset and keeps a saturating count of detected faults. All delays are set in clock cycles through parameters: 10 cycles of tri-state delay and 400 cycles of leakage blanking at a 200 MHz clock.

Top module: `gd_sc_supervisor`

## Requirements
- R1: While reset is asserted and immediately after it is released, drv_oe is 1, drv_gate is 0, ssd_en is 0, sc_flag is 0, integ_rst is 1 and fault_cnt is 0.
- R2: integ_rst equals the inverse of pwm_cmd registered once. With no fault latched, drv_gate equals pwm_cmd registered once.
- R3: Each comparator input passes through a two-flop synchroniser. If qg_above is 0 when the synchronised vg_above rises during PWM high, sc_flag goes to 1 and drv_oe goes to 0 at the third rising clock edge after the comparator change. From that point drv_gate is 0.
- R4: If qg_above is 1 at that rise, no fault is raised. Only the first synchronised vg_above rise in a PWM pulse is evaluated. Later qg_above changes and later vg_above rises in the same pulse have no effect.
- R5: The charge check applies no blanking time. A vg_above rise in the very first cycles after the PWM rising edge is evaluated like any other.
- R6: leak_det is ignored for the first BLANK_CYC cycles that pwm_cmd is high. After that window it raises the same fault sequence as the charge check.
- R7: After a fault, drv_oe and ssd_en are both 0 for exactly DLY_CYC cycles. Then ssd_en goes to 1. drv_oe and ssd_en are never 1 together.
- R8: sc_flag stays 1 while pwm_cmd is high. It clears one edge after pwm_cmd is sampled low, which re-arms detection. fault_cnt increments by exactly one per detected fault and saturates at its maximum.
- R9: If pwm_cmd falls during the tri-state delay, ssd_en never asserts. The next edge restores drv_oe to 1 with drv_gate 0 and clears sc_flag.
- R10: Comparator activity while pwm_cmd is low causes no fault.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_cmd | input | 1 | Synchronous turn-on command |
| qg_above | input | 1 | Asynchronous gate-charge comparator |
| vg_above | input | 1 | Asynchronous gate-voltage comparator |
| leak_det | input | 1 | Asynchronous gate-leakage comparator |
| drv_oe | output | 1 | Driver output enable (0 = high impedance) |
| drv_gate | output | 1 | Driver on/off level |
| ssd_en | output | 1 | Soft-shutdown discharge enable |
| sc_flag | output | 1 | Latched short-circuit flag |
| integ_rst | output | 1 | Charge integrator reset |
| fault_cnt | output | CNT_W | Saturating count of detected faults |

## Verification
The assertions assume that pwm_cmd is synchronous to clk and that the tri-state delay is at least two cycles. They also assume each comparator stays stable long enough to pass the two-flop synchroniser. The stimulus changes every input only at the falling clock edge. It holds each comparator level for several cycles. It clears all comparator inputs at least five cycles before each new PWM pulse, so no stale synchronised level carries across pulses. Leakage onsets are placed at least ten cycles away from the end of the blanking window, so the expected result never depends on a single-cycle boundary.

// File: rtl/gd_sc_pkg.sv
package gd_sc_pkg;
    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_HIZ = 2'd1,
        ST_SSD = 2'd2
    } gd_state_e;
endpackage

// File: rtl/gd_sync_pipe.sv
module gd_sync_pipe #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gd_cycle_timer.sv
module gd_cycle_timer #(
    parameter int LIMIT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1) + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)                       cnt_d = '0;
        else if (cnt_q == CW'(LIMIT))  cnt_d = cnt_q;
        else                           cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/gd_sc_supervisor.sv
module gd_sc_supervisor
    import gd_sc_pkg::*;
#(
    parameter int DLY_CYC     = 10,
    parameter int BLANK_CYC   = 400,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_cmd,
    input  logic             qg_above,
    input  logic             vg_above,
    input  logic             leak_det,
    output logic             drv_oe,
    output logic             drv_gate,
    output logic             ssd_en,
    output logic             sc_flag,
    output logic             integ_rst,
    output logic [CNT_W-1:0] fault_cnt
);
    localparam int NCMP  = 3;
    localparam int DLY_L = DLY_CYC - 1;

    typedef struct packed {
        gd_state_e        st;
        logic             pwm;
        logic             vg_prev;
        logic             sampled;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic [NCMP-1:0] cmp_s;
    logic qg_s, vg_s, lk_s;
    logic blank_open, dly_done;
    logic vg_rise, chg_fault, leak_fault;

    gd_sync_pipe #(.W(NCMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({leak_det, vg_above, qg_above}),
        .dout (cmp_s)
    );

    assign qg_s = cmp_s[0];
    assign vg_s = cmp_s[1];
    assign lk_s = cmp_s[2];

    gd_cycle_timer #(.LIMIT(BLANK_CYC)) u_blank (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!pwm_cmd),
        .done (blank_open)
    );

    gd_cycle_timer #(.LIMIT(DLY_L)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (r_q.st != ST_HIZ),
        .done (dly_done)
    );

    always_comb begin
        r_d         = r_q;
        r_d.pwm     = pwm_cmd;
        r_d.vg_prev = vg_s;

        vg_rise    = vg_s && !r_q.vg_prev;
        chg_fault  = pwm_cmd && (r_q.st == ST_RUN) && vg_rise && !r_q.sampled && !qg_s;
        leak_fault = pwm_cmd && (r_q.st == ST_RUN) && lk_s && blank_open;

        if (!pwm_cmd) begin
            r_d.st      = ST_RUN;
            r_d.sampled = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_RUN: begin
                    if (vg_rise) r_d.sampled = 1'b1;
                    if (chg_fault || leak_fault) begin
                        r_d.st = ST_HIZ;
                        if (!(&r_q.cnt)) r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                ST_HIZ: begin
                    if (dly_done) r_d.st = ST_SSD;
                end
                ST_SSD: begin
                    r_d.st = ST_SSD;
                end
                default: r_d.st = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_RUN;
            r_q.pwm     <= 1'b0;
            r_q.vg_prev <= 1'b0;
            r_q.sampled <= 1'b0;
            r_q.cnt     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drv_oe    = (r_q.st == ST_RUN);
    assign drv_gate  = r_q.pwm && (r_q.st == ST_RUN);
    assign ssd_en    = (r_q.st == ST_SSD);
    assign sc_flag   = (r_q.st != ST_RUN);
    assign integ_rst = !r_q.pwm;
    assign fault_cnt = r_q.cnt;
endmodule

// File: rtl/gd_sc_supervisor_chk.sv
module gd_sc_supervisor_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_cmd,
    input logic             drv_oe,
    input logic             drv_gate,
    input logic             ssd_en,
    input logic             sc_flag,
    input logic             integ_rst,
    input logic [CNT_W-1:0] fault_cnt
);
    AST_OE_SSD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_oe && ssd_en)); // R7
    AST_SSD_AFTER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssd_en) |-> ($past(!drv_oe) && $past(sc_flag))); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_flag && pwm_cmd) |=> sc_flag); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_cmd |=> (!sc_flag && drv_oe && !ssd_en && !drv_gate)); // R9
    AST_INTEG_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_cmd |=> integ_rst); // R2
    AST_GATE_OFF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        sc_flag |-> !drv_gate); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_flag) |-> ((fault_cnt == $past(fault_cnt) + CNT_W'(1)) || (&$past(fault_cnt)))); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sc_flag) |-> $stable(fault_cnt)); // R8
endmodule

bind gd_sc_supervisor gd_sc_supervisor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_cmd  (pwm_cmd),
    .drv_oe   (drv_oe),
    .drv_gate (drv_gate),
    .ssd_en   (ssd_en),
    .sc_flag  (sc_flag),
    .integ_rst(integ_rst),
    .fault_cnt(fault_cnt)
);

// File: tb/tb_gd_sc_supervisor.sv
module tb_gd_sc_supervisor;
    localparam int DLY   = 10;
    localparam int BLANK = 400;
    localparam int CW    = 8;
    localparam int NEVER = 1 << 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_cmd = 1'b0, qg_above = 1'b0, vg_above = 1'b0, leak_det = 1'b0;
    logic drv_oe, drv_gate, ssd_en, sc_flag, integ_rst;
    logic [CW-1:0] fault_cnt;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    gd_sc_supervisor #(.DLY_CYC(DLY), .BLANK_CYC(BLANK), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .qg_above(qg_above),
        .vg_above(vg_above), .leak_det(leak_det), .drv_oe(drv_oe),
        .drv_gate(drv_gate), .ssd_en(ssd_en), .sc_flag(sc_flag),
        .integ_rst(integ_rst), .fault_cnt(fault_cnt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            if (errors <= 30)
                $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    // Expected time (falling-edge index after the PWM rise) at which the fault becomes visible.
    function automatic int fault_time(input int a, input int qgv, input int lk_mode, input int b);
        if (qgv == 0) return a + 3;             // R3: two sync flops plus the state register
        if (lk_mode == 2) return b + 3;         // R6
        return NEVER;
    endfunction

    // lk_mode: 0 none, 1 short pulse inside blanking, 2 held after blanking
    task automatic run_pulse(input int len, input int a, input int qgv, input int bounce,
                             input int lk_mode, input int b, input int w,
                             input string tag, input string idle_tag, input int gap);
        int tf = fault_time(a, qgv, lk_mode, b);
        int base = exp_cnt;
        for (int t = 0; t <= len; t++) begin
            if (t >= 1) begin
                int f = (t >= tf) ? 1 : 0;
                check(tag, "sc_flag", sc_flag, f);
                check(tag, "drv_oe", drv_oe, 1 - f);
                check("R7", "ssd_en", ssd_en, (t >= tf + DLY) ? 1 : 0);
                check("R2", "drv_gate", drv_gate, 1 - f);
                check("R2", "integ_rst", integ_rst, 0);
                check("R8", "fault_cnt", fault_cnt, base + f);
            end
            if (t == 0) pwm_cmd = 1'b1;
            if (t == a) begin vg_above = 1'b1; qg_above = qgv[0]; end
            if (bounce != 0 && t == a + 8) begin vg_above = 1'b0; qg_above = ~qg_above; end
            if (bounce != 0 && t == a + 14) vg_above = 1'b1;
            if (lk_mode != 0 && t == b) leak_det = 1'b1;
            if (lk_mode == 1 && t == b + w) leak_det = 1'b0;
            if (t == len) begin
                pwm_cmd = 1'b0; vg_above = 1'b0; qg_above = 1'b0; leak_det = 1'b0;
            end
            @(negedge clk);
        end
        if (tf <= len) exp_cnt++;
        for (int i = 0; i < gap; i++) begin
            check(idle_tag, "sc_flag idle", sc_flag, 0);
            check(idle_tag, "drv_oe idle", drv_oe, 1);
            check(idle_tag, "ssd_en idle", ssd_en, 0);
            check("R2", "drv_gate idle", drv_gate, 0);
            check("R2", "integ_rst idle", integ_rst, 1);
            check("R10", "fault_cnt idle", fault_cnt, exp_cnt);
            if (i == 1) begin vg_above = 1'b1; qg_above = 1'b0; leak_det = 1'b1; end  // R10 noise
            if (i == gap - 6) begin vg_above = 1'b0; leak_det = 1'b0; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1", "drv_oe in reset", drv_oe, 1);
        check("R1", "ssd_en in reset", ssd_en, 0);
        check("R1", "sc_flag in reset", sc_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "drv_oe", drv_oe, 1);
        check("R1", "drv_gate", drv_gate, 0);
        check("R1", "ssd_en", ssd_en, 0);
        check("R1", "sc_flag", sc_flag, 0);
        check("R1", "integ_rst", integ_rst, 1);
        check("R1", "fault_cnt", fault_cnt, 0);
        repeat (4) @(negedge clk);

        // directed corner cases
        run_pulse(200, 10, 1, 1, 0, 0, 0, "R4", "R8", 12);                  // normal turn-on, bounce ignored
        run_pulse(100, 10, 0, 0, 0, 0, 0, "R3", "R8", 12);                  // short circuit via charge
        run_pulse(60, 0, 0, 0, 0, 0, 0, "R5", "R8", 12);                    // sample right at turn-on
        run_pulse(BLANK + 60, 10, 1, 0, 1, 50, 30, "R6", "R8", 12);         // leak inside blanking
        run_pulse(BLANK + 100, 10, 1, 0, 2, BLANK + 40, 0, "R6", "R8", 12); // leak after blanking
        run_pulse(14, 5, 0, 0, 0, 0, 0, "R9", "R9", 12);                    // abort during tri-state
        run_pulse(40, 3, 0, 1, 0, 0, 0, "R8", "R8", 10);                    // back-to-back faults
        run_pulse(40, 3, 0, 0, 0, 0, 0, "R8", "R8", 10);

        // constrained random pulses
        for (int n = 0; n < 40; n++) begin
            int mode = rnd(0, 2);
            int a    = rnd(0, 30);
            int qgv  = rnd(0, 1);
            int bnc  = rnd(0, 1);
            int len, b, w;
            b = 0; w = 0;
            if (mode == 0) len = rnd(a + 30, 250);
            else len = rnd(BLANK + 60, BLANK + 300);
            if (mode == 1) begin b = rnd(40, BLANK - 40); w = rnd(3, 20); end
            if (mode == 2) b = rnd(BLANK + 10, len - 10);
            run_pulse(len, a, qgv, bnc, mode, b, w,
                      (mode == 0) ? ((qgv != 0) ? "R4" : "R3") : "R6", "R8", rnd(10, 20));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule